// File: doc/BRIEF.md
# Clock Reference Lock State Controller

This block is the mode sequencer for a synchronisation DPLL that follows an external reference clock. It tracks whether the loop is running free, trying to acquire a reference, locked to a reference, or holding the last good frequency after that reference was lost. It also decides when an acquisition attempt has taken too long.

It has two acquisition states. The first is used when the loop comes up from free-run. The second is used when the loop had a valid frequency history: on a new source chosen during holdover, or on a revertive switch back to a restored source of higher priority. Both acquisition states share one timeout counter. The counter advances on a one-second tick and gives up after a parameterised number of ticks. When it gives up, the controller drops back and pulses a request for the selector to choose a different source.

A one-cycle event pulse marks every change of mode, so it can feed an interrupt controller. Source priority sorting, the phase detector and the loop filter live outside this block.

Top module: `lock_state_ctrl`

## Requirements
- R1: Out of reset the mode is Free-Run, and both pulse outputs are low. The mode codes are Free-Run=0, Pre-locked=1, Locked=2, Digital Holdover=3, Pre-locked2=4.
- R2: In Free-Run, a source-selected strobe with the source valid moves the mode to Pre-locked. The same strobe with the source invalid is ignored.
- R3: In Pre-locked or Pre-locked2, lock achieved with the source valid moves the mode to Locked. This takes precedence over a timeout that expires in the same cycle.
- R4: In Locked, loss of source validity moves the mode to Digital Holdover.
- R5: In Digital Holdover, the mode moves to Pre-locked2 on either of two events: a source-selected strobe with the source valid, or a higher-priority-restored strobe while revertive mode is enabled.
- R6: In Locked, a higher-priority-restored strobe moves the mode to Pre-locked2 only while revertive mode is enabled. With revertive mode disabled it is ignored.
- R7: The lock timeout expires on the TIMEOUT_S-th one-second tick counted since entry into an acquisition state. On expiry, Pre-locked2 falls back to Digital Holdover and Pre-locked falls back to Free-Run, and in both cases the request-new-source output pulses.
- R8: Loss of source validity in Pre-locked or Pre-locked2 causes the same fallback and request pulse as a timeout.
- R9: In Pre-locked2, a higher-priority-restored strobe with revertive mode enabled restarts the timeout from zero. The mode stays the same and no mode-change event is raised.
- R10: The mode-change output is a one-cycle pulse in the first cycle that shows a new mode. It is raised on every change of mode and at no other time.
- R11: The request-new-source output is a one-cycle pulse. It is raised only together with a fallback out of an acquisition state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Strobe: a source has been selected and applied to the loop |
| lock_i | input | 1 | Lock achieved on the applied source |
| src_ok_i | input | 1 | Selected source is valid (low means failed) |
| revert_en_i | input | 1 | Revertive mode enable |
| hiprio_rest_i | input | 1 | Strobe: a higher-priority source has been restored |
| tick_1s_i | input | 1 | One-second tick, one cycle wide |
| mode_o | output | 3 | Current mode code |
| req_new_src_o | output | 1 | Pulse: select another source |
| mode_evt_o | output | 1 | Pulse: mode changed |

## Verification
The bench builds the controller with TIMEOUT_S=4. This puts every tick count from zero up to the expiry point within a short run. For each count from 0 to 4, the bench re-enters Pre-locked2 and checks that lock is still accepted before expiry and that the fourth tick forces holdover with a request. The short window also allows the bench to check a revertive restart at three ticks, lock and expiry arriving in the same cycle, and the Pre-locked timeout into Free-Run.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    M_FREE = 3'd0,
    M_PRE  = 3'd1,
    M_LOCK = 3'd2,
    M_HOLD = 3'd3,
    M_PRE2 = 3'd4
  } mode_e;
endpackage

// File: rtl/lsc_timer.sv
module lsc_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !run_i)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsc_next.sv
module lsc_next
  import lsc_pkg::*;
(
  input  mode_e cur_i,
  input  logic  sel_i,
  input  logic  lock_i,
  input  logic  ok_i,
  input  logic  rev_i,
  input  logic  hp_i,
  input  logic  expire_i,
  output mode_e nxt_o,
  output logic  req_o,
  output logic  restart_o
);
  logic revert;
  assign revert = rev_i && hp_i;

  always_comb begin
    nxt_o     = cur_i;
    req_o     = 1'b0;
    restart_o = 1'b0;
    unique case (cur_i)
      M_FREE: if (sel_i && ok_i) nxt_o = M_PRE;
      M_PRE: begin
        if (lock_i && ok_i) nxt_o = M_LOCK;
        else if (!ok_i || expire_i) begin
          nxt_o = M_FREE;
          req_o = 1'b1;
        end
      end
      M_LOCK: begin
        if (!ok_i)       nxt_o = M_HOLD;
        else if (revert) nxt_o = M_PRE2;
      end
      M_HOLD: if ((sel_i && ok_i) || revert) nxt_o = M_PRE2;
      M_PRE2: begin
        if (lock_i && ok_i) nxt_o = M_LOCK;
        else if (!ok_i || expire_i) begin
          nxt_o = M_HOLD;
          req_o = 1'b1;
        end else if (revert) restart_o = 1'b1;
      end
      default: nxt_o = M_FREE;
    endcase
  end
endmodule

// File: rtl/lock_state_ctrl.sv
module lock_state_ctrl
  import lsc_pkg::*;
#(
  parameter int TIMEOUT_S = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_sel_i,
  input  logic       lock_i,
  input  logic       src_ok_i,
  input  logic       revert_en_i,
  input  logic       hiprio_rest_i,
  input  logic       tick_1s_i,
  output logic [2:0] mode_o,
  output logic       req_new_src_o,
  output logic       mode_evt_o
);
  mode_e cur_q, nxt;
  logic  req_d, restart, expire, in_acq, req_q, evt_q;

  assign in_acq = (cur_q == M_PRE) || (cur_q == M_PRE2);

  lsc_next u_next (
    .cur_i    (cur_q),
    .sel_i    (src_sel_i),
    .lock_i   (lock_i),
    .ok_i     (src_ok_i),
    .rev_i    (revert_en_i),
    .hp_i     (hiprio_rest_i),
    .expire_i (expire),
    .nxt_o    (nxt),
    .req_o    (req_d),
    .restart_o(restart)
  );

  lsc_timer #(.LIMIT(TIMEOUT_S)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_acq),
    .clr_i   ((nxt != cur_q) || restart),
    .tick_i  (tick_1s_i),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= M_FREE;
      req_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      req_q <= req_d;
      evt_q <= (nxt != cur_q);
    end
  end

  assign mode_o        = cur_q;
  assign req_new_src_o = req_q;
  assign mode_evt_o    = evt_q;
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int TIMEOUT_S = 100
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       src_ok_i,
  input logic       revert_en_i,
  input logic       hiprio_rest_i,
  input logic       tick_1s_i,
  input logic [2:0] mode_o,
  input logic       req_new_src_o,
  input logic       mode_evt_o
);
  logic [2:0] pm_q;
  int         dwell_q, dwell_base;
  logic       acq;

  assign acq        = (mode_o == 3'd1) || (mode_o == 3'd4);
  assign dwell_base = (mode_o != pm_q) ? 0 : dwell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_q    <= 3'd0;
      dwell_q <= 0;
    end else begin
      pm_q <= mode_o;
      if (!acq || (mode_o == 3'd4 && revert_en_i && hiprio_rest_i)) dwell_q <= 0;
      else dwell_q <= dwell_base + (tick_1s_i ? 1 : 0);
    end
  end

  assert_legal_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);
  assert_lost_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && !src_ok_i) |=> mode_o == 3'd3);
  assert_dwell_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq |-> dwell_base < TIMEOUT_S);
  assert_evt_on_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> mode_evt_o);
  assert_evt_only_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_evt_o |-> (mode_o != $past(mode_o)));
  assert_req_fallback_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_new_src_o |-> ((mode_o == 3'd3 && $past(mode_o) == 3'd4) ||
                       (mode_o == 3'd0 && $past(mode_o) == 3'd1)));
  assert_req_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_new_src_o |=> !req_new_src_o);
endmodule

bind lock_state_ctrl lsc_chk #(.TIMEOUT_S(TIMEOUT_S)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_ok_i     (src_ok_i),
  .revert_en_i  (revert_en_i),
  .hiprio_rest_i(hiprio_rest_i),
  .tick_1s_i    (tick_1s_i),
  .mode_o       (mode_o),
  .req_new_src_o(req_new_src_o),
  .mode_evt_o   (mode_evt_o)
);

// File: tb/tb_lock_state_ctrl.sv
module tb_lock_state_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, lck = 0, ok = 0, rev = 0, hp = 0, tick = 0;
  logic [2:0] mode;
  logic req, evt;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_state_ctrl #(.TIMEOUT_S(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel), .lock_i(lck),
    .src_ok_i(ok), .revert_en_i(rev), .hiprio_rest_i(hp), .tick_1s_i(tick),
    .mode_o(mode), .req_new_src_o(req), .mode_evt_o(evt)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // drive strobes for one cycle at a negedge, return at the next negedge
  task automatic cyc(input logic s, input logic l, input logic h, input logic t);
    sel = s; lck = l; hp = h; tick = t;
    @(negedge clk);
    sel = 0; lck = 0; hp = 0; tick = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; sel = 0; lck = 0; hp = 0; tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ok = 0; rev = 0;
    do_reset();
    chk("R1 mode", mode, 0);
    chk("R1 req", req, 0);
    chk("R1 evt", evt, 0);

    cyc(1, 0, 0, 0);
    chk("R2 sel ignored without ok", mode, 0);
    ok = 1;
    cyc(1, 0, 0, 0);
    chk("R2 free->pre", mode, 1);
    chk("R10 evt", evt, 1);
    cyc(0, 0, 0, 0);
    chk("R10 evt single", evt, 0);
    chk("R2 stays pre", mode, 1);
    cyc(0, 1, 0, 0);
    chk("R3 pre->lock", mode, 2);
    ok = 0;
    cyc(0, 0, 0, 0);
    chk("R4 lock->hold", mode, 3);
    chk("R4 evt", evt, 1);
    chk("R11 no req", req, 0);
    ok = 1;

    // sweep tick counts across the timeout window
    for (int k = 0; k <= TO; k++) begin
      cyc(1, 0, 0, 0);
      chk("R5 hold->pre2", mode, 4);
      for (int j = 1; j <= k; j++) begin
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        chk("R7 dwell mode", mode, (j < TO) ? 4 : 3);
        if (j == TO) begin
          chk("R11 req cleared", req, 0);
        end
      end
      if (k < TO) begin
        cyc(0, 1, 0, 0);
        chk("R3 pre2->lock", mode, 2);
        ok = 0;
        cyc(0, 0, 0, 0);
        chk("R4 lock->hold", mode, 3);
        ok = 1;
      end
    end

    // expiry cycle shows request exactly once
    cyc(1, 0, 0, 0);
    for (int j = 1; j < TO; j++) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R7 expiry to hold", mode, 3);
    chk("R7 req on expiry", req, 1);
    chk("R10 evt on expiry", evt, 1);
    cyc(0, 0, 0, 0);
    chk("R11 req single", req, 0);

    // revertive restart in pre2
    cyc(1, 0, 0, 0);
    for (int j = 1; j < TO; j++) cyc(0, 0, 0, 1);
    rev = 1;
    cyc(0, 0, 1, 0);
    chk("R9 restart keeps mode", mode, 4);
    chk("R9 restart no evt", evt, 0);
    rev = 0;
    for (int j = 1; j < TO; j++) cyc(0, 0, 0, 1);
    chk("R9 timer restarted", mode, 4);
    cyc(0, 0, 0, 1);
    chk("R9 expires after full window", mode, 3);
    chk("R7 req after restart", req, 1);

    // revertive entries
    rev = 1;
    cyc(0, 0, 1, 0);
    chk("R5 hold revert->pre2", mode, 4);
    cyc(0, 1, 0, 0);
    chk("R3 lock", mode, 2);
    rev = 0;
    cyc(0, 0, 1, 0);
    chk("R6 ignored without revert", mode, 2);
    chk("R6 no evt", evt, 0);
    rev = 1;
    cyc(0, 0, 1, 0);
    chk("R6 lock revert->pre2", mode, 4);
    rev = 0;
    ok = 0;
    cyc(0, 0, 0, 0);
    chk("R8 pre2 fail->hold", mode, 3);
    chk("R8 req", req, 1);
    ok = 1;

    // lock beats expiry in same cycle
    cyc(1, 0, 0, 0);
    for (int j = 1; j < TO; j++) cyc(0, 0, 0, 1);
    cyc(0, 1, 0, 1);
    chk("R3 lock over expiry", mode, 2);
    chk("R3 no req", req, 0);

    // pre-locked fallbacks to free-run
    do_reset();
    chk("R1 mode after reset", mode, 0);
    cyc(1, 0, 0, 0);
    for (int j = 1; j < TO; j++) cyc(0, 0, 0, 1);
    chk("R7 pre dwell", mode, 1);
    cyc(0, 0, 0, 1);
    chk("R7 pre expiry->free", mode, 0);
    chk("R7 pre req", req, 1);
    cyc(1, 0, 0, 0);
    chk("R2 re-enter pre", mode, 1);
    ok = 0;
    cyc(0, 0, 0, 0);
    chk("R8 pre fail->free", mode, 0);
    chk("R8 pre req", req, 1);
    cyc(0, 0, 0, 0);
    chk("R11 req single", req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule